// File: doc/BRIEF.md
# Delayed-branch program counter sequencer

This block keeps the program counter of a vector coprocessor whose instructions are all 8 bytes wide and whose code lives in a 16 KB space. Each pulse on the step strobe moves execution forward by one instruction. Decode can ask for a PC-relative branch or an absolute jump. The new target takes effect only after a parameterised number of delay-slot instructions has been stepped. Until then the target is presented on an output, so that link-type instructions can write it to a register.

A branch requested while another is still counting down is queued rather than dropped. When the first target is loaded, exactly one instruction runs there and the following step moves to the queued target. There is room for one queued branch only. A further request is discarded and raises a sticky overflow flag.

Top module: `dps_seq`

## Requirements
- R1: A synchronous active-high reset clears the PC, the stored target, the queued target, the countdown and the overflow flag to zero.
- R2: A step with no branch expiring adds 8 to the PC, wrapping modulo 16384. With no step, the PC holds its value.
- R3: A relative request (rel_i=1) computes its target as (PC + 8 + sext(imm_i)*8) AND 0x3FFF. imm_i is an 11-bit two's-complement value, and PC is the value shown on pc_o in the request cycle. When rel_i and abs_i are both high, the relative form is used.
- R4: An absolute request (abs_i=1, rel_i=0) computes its target as (jaddr_i*8) AND 0x3FFF, where jaddr_i is an 11-bit unsigned field.
- R5: A request accepted while no branch is pending sets up a countdown. The next DELAY_SLOTS steps each add 8. The step after them loads the target into the PC.
- R6: A request and a step in the same cycle are handled with the request first. That step already counts as the first step of the new countdown.
- R7: tgt_o shows the stored target from the cycle after a branch is accepted. It keeps that value after the target has been loaded into the PC.
- R8: A request made while a branch is pending is queued as a second target. tgt_o keeps the first target.
- R9: When the first target is loaded and a second target is queued, the next step runs one instruction at the first target. The step after that loads the second target, and tgt_o shows the second target from the load of the first.
- R10: A request made while a second target is already queued is ignored. It changes neither the PC nor tgt_o, and overflow_o goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance by one instruction |
| rel_i | input | 1 | PC-relative branch request |
| abs_i | input | 1 | Absolute jump request |
| imm_i | input | IMM_W (11) | Signed relative offset in instructions |
| jaddr_i | input | JMP_W (11) | Absolute target in instructions |
| pc_o | output | PC_W (14) | Current program counter (byte address) |
| tgt_o | output | PC_W (14) | Stored branch target for link instructions |
| overflow_o | output | 1 | Sticky flag: a request was lost to a full queue |

## Verification
The assertions assume a synchronous reset held for at least one clock before it is released, and inputs that are known at every rising edge. They place no restriction on how requests and steps combine in a cycle: both request kinds, steps and any mix of them may arrive together. The stimulus drives every input at the falling edge to known values. It covers directed single, double and triple branch sequences, requests that arrive with and without a step, and a long constrained-random stretch.

// File: rtl/dps_pkg.sv
package dps_pkg;
  // log2 of the instruction size in bytes (8-byte instructions)
  localparam int unsigned INSN_SHIFT = 3;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_REL  = 2'd1,
    REQ_ABS  = 2'd2
  } req_kind_e;
endpackage

// File: rtl/dps_target_gen.sv
module dps_target_gen
  import dps_pkg::*;
#(
  parameter int unsigned PC_W  = 14,
  parameter int unsigned IMM_W = 11,
  parameter int unsigned JMP_W = 11
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             rel,
  input  logic             abs_req,
  input  logic [IMM_W-1:0] imm,
  input  logic [JMP_W-1:0] jaddr,
  output logic             req_valid,
  output logic [PC_W-1:0]  req_tgt
);
  localparam logic [PC_W-1:0] STEP_BYTES = PC_W'(1) << INSN_SHIFT;

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base,
                                                  input logic [IMM_W-1:0] off);
    logic [PC_W-1:0] off_ext;
    off_ext = {{(PC_W-IMM_W){off[IMM_W-1]}}, off};
    return base + STEP_BYTES + (off_ext << INSN_SHIFT);
  endfunction

  function automatic logic [PC_W-1:0] abs_target(input logic [JMP_W-1:0] field);
    logic [JMP_W+INSN_SHIFT-1:0] wide;
    wide = {field, {INSN_SHIFT{1'b0}}};
    return PC_W'(wide);
  endfunction

  req_kind_e kind;

  always_comb begin
    if (rel)          kind = REQ_REL;
    else if (abs_req) kind = REQ_ABS;
    else              kind = REQ_NONE;
  end

  assign req_valid = (kind != REQ_NONE);

  always_comb begin
    unique case (kind)
      REQ_REL: req_tgt = rel_target(pc, imm);
      REQ_ABS: req_tgt = abs_target(jaddr);
      default: req_tgt = '0;
    endcase
  end
endmodule

// File: rtl/dps_branch_ctrl.sv
module dps_branch_ctrl #(
  parameter int unsigned DELAY_SLOTS = 1,
  parameter int unsigned PC_W        = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            req_valid,
  input  logic [PC_W-1:0] req_tgt,
  output logic [PC_W-1:0] tgt_q,
  output logic            overflow_q,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc,
  output logic            req_first,
  output logic            req_second,
  output logic            req_drop,
  output logic            promote
);
  localparam int unsigned CNT_W = $clog2(DELAY_SLOTS + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_a, cnt_n;
  logic [PC_W-1:0]  tgt_a, tgt_n;
  logic             sec_v_q, sec_v_a, sec_v_n;
  logic [PC_W-1:0]  sec_t_q, sec_t_a, sec_t_n;

  // Phase 1: the request is applied to the current state
  always_comb begin
    cnt_a      = cnt_q;
    tgt_a      = tgt_q;
    sec_v_a    = sec_v_q;
    sec_t_a    = sec_t_q;
    req_first  = 1'b0;
    req_second = 1'b0;
    req_drop   = 1'b0;
    if (req_valid) begin
      if (cnt_q == '0) begin
        req_first = 1'b1;
        cnt_a     = CNT_LOAD;
        tgt_a     = req_tgt;
      end else if (!sec_v_q) begin
        req_second = 1'b1;
        sec_v_a    = 1'b1;
        sec_t_a    = req_tgt;
      end else begin
        req_drop = 1'b1;
      end
    end
  end

  // Phase 2: the step acts on the post-request state
  always_comb begin
    cnt_n       = cnt_a;
    tgt_n       = tgt_a;
    sec_v_n     = sec_v_a;
    sec_t_n     = sec_t_a;
    redirect    = 1'b0;
    promote     = 1'b0;
    redirect_pc = tgt_a;
    if (step && (cnt_a != '0)) begin
      cnt_n = cnt_a - CNT_ONE;
      if (cnt_a == CNT_ONE) begin
        redirect = 1'b1;
        if (sec_v_a) begin
          promote = 1'b1;
          tgt_n   = sec_t_a;
          sec_v_n = 1'b0;
          cnt_n   = CNT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      tgt_q      <= '0;
      sec_v_q    <= 1'b0;
      sec_t_q    <= '0;
      overflow_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_n;
      tgt_q      <= tgt_n;
      sec_v_q    <= sec_v_n;
      sec_t_q    <= sec_t_n;
      overflow_q <= overflow_q | req_drop;
    end
  end
endmodule

// File: rtl/dps_pc_reg.sv
module dps_pc_reg
  import dps_pkg::*;
#(
  parameter int unsigned PC_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] STEP_BYTES = PC_W'(1) << INSN_SHIFT;

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] cur);
    return cur + STEP_BYTES;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= '0;
    else if (step)     pc_q <= redirect ? redirect_pc : seq_next(pc_q);
  end
endmodule

// File: rtl/dps_seq.sv
module dps_seq #(
  parameter int unsigned DELAY_SLOTS = 1,
  parameter int unsigned PC_W        = 14,
  parameter int unsigned IMM_W       = 11,
  parameter int unsigned JMP_W       = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             rel_i,
  input  logic             abs_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [JMP_W-1:0] jaddr_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  tgt_o,
  output logic             overflow_o
);
  logic            req_valid;
  logic [PC_W-1:0] req_tgt;
  logic            redirect;
  logic [PC_W-1:0] redirect_pc;
  logic            req_first, req_second, req_drop, promote;

  dps_target_gen #(.PC_W(PC_W), .IMM_W(IMM_W), .JMP_W(JMP_W)) u_tgen (
    .pc        (pc_o),
    .rel       (rel_i),
    .abs_req   (abs_i),
    .imm       (imm_i),
    .jaddr     (jaddr_i),
    .req_valid (req_valid),
    .req_tgt   (req_tgt)
  );

  dps_branch_ctrl #(.DELAY_SLOTS(DELAY_SLOTS), .PC_W(PC_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .step        (step_i),
    .req_valid   (req_valid),
    .req_tgt     (req_tgt),
    .tgt_q       (tgt_o),
    .overflow_q  (overflow_o),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .req_first   (req_first),
    .req_second  (req_second),
    .req_drop    (req_drop),
    .promote     (promote)
  );

  dps_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .step        (step_i),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .pc_q        (pc_o)
  );
endmodule

// File: rtl/dps_seq_chk.sv
module dps_seq_chk #(
  parameter int unsigned PC_W = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            step_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] tgt_o,
  input logic            overflow_o,
  input logic            redirect,
  input logic [PC_W-1:0] redirect_pc,
  input logic            req_first,
  input logic            req_second,
  input logic            req_drop,
  input logic            promote
);
  localparam logic [PC_W-1:0] EIGHT = PC_W'(8);

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pc_o));

  p_pc_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !redirect) |=> (pc_o == $past(pc_o) + EIGHT));

  p_redirect_load_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc_o == $past(redirect_pc)));

  p_redirect_on_step_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |-> step_i);

  p_first_sets_tgt_r7: assert property (@(posedge clk) disable iff (rst)
    (req_first && !redirect) |=> (tgt_o == $past(redirect_pc)));

  p_second_keeps_tgt_r8: assert property (@(posedge clk) disable iff (rst)
    (req_second && !promote) |=> $stable(tgt_o));

  p_promote_with_load_r9: assert property (@(posedge clk) disable iff (rst)
    promote |-> redirect);

  p_drop_flags_r10: assert property (@(posedge clk) disable iff (rst)
    req_drop |=> overflow_o);

  p_no_overflow_drop_r10: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_first, req_second, req_drop}));
endmodule

bind dps_seq dps_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_i      (step_i),
  .pc_o        (pc_o),
  .tgt_o       (tgt_o),
  .overflow_o  (overflow_o),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .req_first   (req_first),
  .req_second  (req_second),
  .req_drop    (req_drop),
  .promote     (promote)
);

// File: tb/dps_seq_tb.sv
module dps_seq_tb;
  localparam int CLK_P = 10;
  localparam int D     = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0, rel_i = 1'b0, abs_i = 1'b0;
  logic [10:0] imm_i = '0, jaddr_i = '0;
  logic [13:0] pc_o, tgt_o;
  logic        overflow_o;

  dps_seq #(.DELAY_SLOTS(D)) u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .rel_i(rel_i), .abs_i(abs_i),
    .imm_i(imm_i), .jaddr_i(jaddr_i), .pc_o(pc_o), .tgt_o(tgt_o),
    .overflow_o(overflow_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int    pc;
    int    tgt;
    bit    ovf;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state: steps left until the target is taken, plus one queue slot
  int  m_pc, m_tgt, m_left, m_qt;
  bit  m_qv, m_ovf;

  task automatic model_clear();
    m_pc = 0; m_tgt = 0; m_left = 0; m_qt = 0; m_qv = 0; m_ovf = 0;
  endtask

  task automatic drive(input bit s, input bit rl, input bit ab,
                       input int imm, input int j, input string tag);
    int t;
    exp_t e;
    @(negedge clk);
    step_i = s; rel_i = rl; abs_i = ab;
    imm_i = imm[10:0]; jaddr_i = j[10:0];
    if (rl || ab) begin
      if (rl) t = (m_pc + 8 + imm * 8) & 'h3FFF;
      else    t = (j * 8) & 'h3FFF;
      if (m_left == 0) begin
        m_tgt = t; m_left = D + 1;
      end else if (!m_qv) begin
        m_qv = 1; m_qt = t;
      end else begin
        m_ovf = 1;
      end
    end
    if (s) begin
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_pc = m_tgt;
          if (m_qv) begin
            m_tgt = m_qt; m_qv = 0; m_left = 1;
          end
        end else m_pc = (m_pc + 8) & 'h3FFF;
      end else m_pc = (m_pc + 8) & 'h3FFF;
    end
    e.pc = m_pc; e.tgt = m_tgt; e.ovf = m_ovf; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    step_i = 0; rel_i = 0; abs_i = 0;
  endtask

  task automatic check_now(input int pc, input int tgt, input bit ovf, input string tag);
    checks++;
    if (int'(pc_o) != pc || int'(tgt_o) != tgt || overflow_o != ovf) begin
      fails++;
      $display("FAIL %s: pc=%0d tgt=%0d ovf=%0d expected pc=%0d tgt=%0d ovf=%0d",
               tag, pc_o, tgt_o, overflow_o, pc, tgt, ovf);
    end
  endtask

  // Monitor: compare one expected item per clock, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check_now(e.pc, e.tgt, e.ovf, e.tag);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; step_i = 0; rel_i = 0; abs_i = 0;
    @(negedge clk);
    rst = 0;
    model_clear();
    check_now(0, 0, 0, "R1 reset");
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_now(0, 0, 0, "R1 reset");

    // R2: plain stepping, and holding without a step
    drive(1, 0, 0, 0, 0, "R2 step");
    drive(1, 0, 0, 0, 0, "R2 step");
    drive(1, 0, 0, 0, 0, "R2 step");
    drive(0, 0, 0, 0, 0, "R2 hold");
    // R3/R5/R7: relative +4 from pc 24 -> 64, one delay slot
    drive(0, 1, 0, 4, 0, "R3 rel request");
    drive(1, 0, 0, 0, 0, "R5 delay slot");
    drive(1, 0, 0, 0, 0, "R5 load target");
    drive(1, 0, 0, 0, 0, "R7 tgt kept after load");
    // R4/R6: absolute with step in the same cycle
    drive(1, 0, 1, 0, 100, "R6 abs with step");
    drive(1, 0, 0, 0, 0, "R4 abs target loaded");
    // R3: negative offset with wrap below zero
    drive(0, 1, 0, -200, 0, "R3 negative rel");
    drive(1, 0, 0, 0, 0, "R3 slot");
    drive(1, 0, 0, 0, 0, "R3 wrapped target");
    // R4/R2: top of space then PC wrap past 16 KB
    drive(0, 0, 1, 0, 2047, "R4 abs max");
    drive(1, 0, 0, 0, 0, "R4 slot");
    drive(1, 0, 0, 0, 0, "R4 top target");
    drive(1, 0, 0, 0, 0, "R2 wrap to zero");
    // R8/R9: second branch in the delay slot
    drive(0, 0, 1, 0, 10, "R8 first");
    drive(0, 0, 1, 0, 20, "R8 second queued");
    drive(1, 0, 0, 0, 0, "R9 delay slot");
    drive(1, 0, 0, 0, 0, "R9 first target");
    drive(1, 0, 0, 0, 0, "R9 second target");
    drive(1, 0, 0, 0, 0, "R9 after second");
    // R3: both request kinds together, relative wins
    drive(0, 1, 1, 2, 500, "R3 rel priority");
    drive(1, 0, 0, 0, 0, "R3 slot");
    drive(1, 0, 0, 0, 0, "R3 rel taken");
    // R10: a third branch is dropped and flags overflow
    drive(0, 0, 1, 0, 30, "R10 first");
    drive(0, 0, 1, 0, 40, "R10 second");
    drive(0, 0, 1, 0, 50, "R10 third dropped");
    drive(1, 0, 0, 0, 0, "R10 slot");
    drive(1, 0, 0, 0, 0, "R10 first taken");
    drive(1, 0, 0, 0, 0, "R10 second taken");
    drive(1, 0, 0, 0, 0, "R10 sticky");
    idle();
    repeat (3) @(negedge clk);
    do_reset();

    // Mixed random traffic against the reference state
    for (int i = 0; i < 400; i++) begin
      int r;
      bit s, rl, ab;
      r  = int'($urandom_range(0, 99));
      s  = (r % 10) < 7;
      rl = r < 12;
      ab = (r >= 12) && (r < 24);
      drive(s, rl, ab, int'($urandom_range(0, 2047)) - 1024,
            int'($urandom_range(0, 2047)), "R5 R8 R9 R10 random");
      if (i == 200) begin
        idle();
        repeat (2) @(negedge clk);
        do_reset();
      end
    end
    idle();
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule